// File: doc/BRIEF.md
# Color Lookup Table with Pixel Format Expansion

This block holds a 256-entry color lookup table for a display pipeline. Software-side logic fills it one 32-bit word at a time, and each word carries two table entries. The pixel path then looks entries up by an 8-bit index. Each entry stores three 5-bit color components, which the block reads back as red, green and blue.

On every lookup, the stored color is widened to 8 bits per component. It is then reduced to the output layout chosen on the format input: 3:3:2, 5:5:5, 5:6:5 or 8:8:8. The converted pixel appears one clock after the request, together with a valid flag. The format is captured together with the index, so a stream of lookups may change format from one cycle to the next.

Top module: `pal_lut`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_pixel` is 0.
- R2: A write to word address w stores `wr_data[15:0]` as entry 2w and `wr_data[31:16]` as entry 2w+1.
- R3: Bit 15 of each 16-bit half (the intensity bit) is discarded and has no effect on any output.
- R4: Within an entry, red is bits 4:0, green is bits 9:5 and blue is bits 14:10. Each component is widened to 8 bits by appending three zero bits below it (r8 = {r5,000}).
- R5: With `fmt` = 0, `out_pixel[7:0]` = {r8[7:5], g8[7:5], b8[7:6]} and bits 23:8 are 0.
- R6: With `fmt` = 1, `out_pixel[14:0]` = {r8[7:3], g8[7:3], b8[7:3]} and bits 23:15 are 0.
- R7: With `fmt` = 2, `out_pixel[15:0]` = {r8[7:3], g8[7:2], b8[7:3]} and bits 23:16 are 0.
- R8: With `fmt` = 3, `out_pixel` = {r8, g8, b8}, with red in bits 23:16 and blue in bits 7:0.
- R9: `out_valid` equals `rd_valid` delayed by one clock. The pixel returned belongs to the `rd_index` and `fmt` sampled with that request.
- R10: A write and a lookup that touch the same entry in the same cycle return the entry's value from before the write; the next lookup returns the new value.
- R11: While `out_valid` is 0, `out_pixel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one table word |
| wr_addr | input | 7 | Word address; selects entries 2w and 2w+1 |
| wr_data | input | 32 | Two packed 16-bit entries |
| rd_valid | input | 1 | Lookup request |
| rd_index | input | 8 | Entry to look up |
| fmt | input | 2 | Output format: 0=3:3:2, 1=5:5:5, 2=5:6:5, 3=8:8:8 |
| out_valid | output | 1 | Converted pixel is valid |
| out_pixel | output | 24 | Converted pixel, right-aligned |

## Verification
A table write and a lookup can happen in the same clock. The bench provokes this by writing a word while it requests one of that word's two entries. It judges the result against the value the bench recorded before that write, and it checks a lookup issued on the following cycle against the newly written data. Around this case, every entry is swept in all four formats as a back-to-back stream. The format changes on stream boundaries, and the expected pixel is computed arithmetically from the written words.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Output pixel layout; the numeric codes are visible on the fmt port.
    typedef enum logic [1:0] {
        PF_RGB332 = 2'd0,
        PF_RGB555 = 2'd1,
        PF_RGB565 = 2'd2,
        PF_RGB888 = 2'd3
    } pix_fmt_e;

    localparam int COMP_W = 5;
    localparam int WIDE_W = 8;
    localparam int ENT_W  = 3 * COMP_W;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;
    localparam int PIX_W  = 3 * WIDE_W;

endpackage

// File: rtl/pal_bank.sv
// One half of the table: holds either the even or the odd entries.
module pal_bank #(
    parameter int AW = 7,
    parameter int EW = 15
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [EW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [EW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [EW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // The read is taken before this edge's write lands, so a
    // simultaneous write to the same slot yields the prior contents.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/pal_fmt.sv
// Widens 5-bit components and packs them into the selected layout.
module pal_fmt
    import pal_pkg::*;
(
    input  logic [ENT_W-1:0] ent,
    input  pix_fmt_e         sel,
    output logic [PIX_W-1:0] pix
);
    logic [WIDE_W-1:0] red8, grn8, blu8;

    always_comb begin
        red8 = {ent[COMP_W-1:0],          3'b000};
        grn8 = {ent[2*COMP_W-1:COMP_W],   3'b000};
        blu8 = {ent[3*COMP_W-1:2*COMP_W], 3'b000};
        unique case (sel)
            PF_RGB332: pix = {16'd0, red8[7:5], grn8[7:5], blu8[7:6]};
            PF_RGB555: pix = {9'd0,  red8[7:3], grn8[7:3], blu8[7:3]};
            PF_RGB565: pix = {8'd0,  red8[7:3], grn8[7:2], blu8[7:3]};
            default:   pix = {red8, grn8, blu8};
        endcase
    end

endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-2:0]   wr_addr,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_valid,
    input  logic [IDX_W-1:0]   rd_index,
    input  logic [1:0]         fmt,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_pixel
);
    localparam int AW    = IDX_W - 1;
    localparam int BANKS = 2;

    typedef struct packed {
        logic             vld;
        logic [ENT_W-1:0] raw;
        pix_fmt_e         sel;
    } stage_t;

    stage_t st_d, st_q;
    logic [ENT_W-1:0] bank_rd [BANKS];

    // Even entries live in bank 0 (low half-word), odd in bank 1.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        pal_bank #(.AW(AW), .EW(ENT_W)) u_bank (
            .clk   (clk),
            .we    (wr_en),
            .waddr (wr_addr),
            .wdata (wr_data[b*HALF_W +: ENT_W]),
            .raddr (rd_index[IDX_W-1:1]),
            .rdata (bank_rd[b])
        );
    end

    always_comb begin
        st_d     = '0;
        st_d.vld = rd_valid;
        if (rd_valid) begin
            st_d.raw = bank_rd[rd_index[0]];
            st_d.sel = pix_fmt_e'(fmt);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pal_fmt u_fmt (
        .ent (st_q.raw),
        .sel (st_q.sel),
        .pix (out_pixel)
    );

    assign out_valid = st_q.vld;

    p_req_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);
    p_idle_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);
    p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_pixel == '0);
    p_332_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt) == 2'd0) |-> out_pixel[23:8] == '0);
    p_555_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt) == 2'd1) |-> out_pixel[23:15] == '0);
    p_565_glsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt) == 2'd2) |-> (out_pixel[23:16] == '0 && !out_pixel[5]));
    p_888_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(fmt) == 2'd3) |->
            (out_pixel[2:0] == '0 && out_pixel[10:8] == '0 && out_pixel[18:16] == '0));

endmodule

// File: tb/sim_pal_lut.sv
module sim_pal_lut;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [6:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_valid = 0;
    logic [7:0]  rd_index = '0;
    logic [1:0]  fmt = '0;
    logic        out_valid;
    logic [23:0] out_pixel;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] shadow [256];
    bit          p_vld = 0;
    logic [23:0] p_exp = '0;
    string       p_tag = "";

    always #10 clk = ~clk;

    pal_lut u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_valid(rd_valid), .rd_index(rd_index),
        .fmt(fmt), .out_valid(out_valid), .out_pixel(out_pixel)
    );

    function automatic logic [23:0] calc_pix(input logic [15:0] e, input int f);
        int r8 = int'(e & 16'h1f) * 8;
        int g8 = int'((e >> 5) & 16'h1f) * 8;
        int b8 = int'((e >> 10) & 16'h1f) * 8;
        case (f)
            0:       return 24'((r8 / 32) * 32 + (g8 / 32) * 4 + b8 / 64);
            1:       return 24'((r8 / 8) * 1024 + (g8 / 8) * 32 + b8 / 8);
            2:       return 24'((r8 / 8) * 2048 + (g8 / 4) * 32 + b8 / 8);
            default: return 24'(r8 * 65536 + g8 * 256 + b8);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: judge the previous request, then drive this cycle's inputs.
    task automatic step(input bit rv, input int idx, input int f,
                        input bit we, input int wa, input logic [31:0] wd,
                        input string tag);
        @(negedge clk);
        if (p_vld) begin
            check({"R9 ", p_tag}, 32'(out_valid), 32'd1);
            check(p_tag, 32'(out_pixel), 32'(p_exp));
        end else begin
            check("R11 idle", {8'd0, out_pixel} | 32'(out_valid), 32'd0);
        end
        rd_valid = rv; rd_index = 8'(idx); fmt = 2'(f);
        wr_en = we; wr_addr = 7'(wa); wr_data = wd;
        p_vld = rv;
        if (rv) p_exp = calc_pix(shadow[idx], f);
        p_tag = tag;
        if (we) begin
            shadow[2*wa]   = wd[15:0]  & 16'h7fff;   // R3: intensity bit dropped
            shadow[2*wa+1] = wd[31:16] & 16'h7fff;   // R2: high half -> odd entry
        end
    endtask

    function automatic logic [31:0] pattern(input int w);
        return (32'(w) * 32'h9e37_79b1) ^ (32'(w) << 11) ^ 32'h5a5a_0f0f;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1 valid", 32'(out_valid), 32'd0);
        check("R1 pixel", 32'(out_pixel), 32'd0);
        rst_n = 1;
        // Fill the whole table (R2), checking the idle output each cycle (R11).
        for (int w = 0; w < 128; w++) step(0, 0, 0, 1, w, pattern(w), "");
        // Sweep every entry in every format as a back-to-back stream (R4).
        for (int f = 0; f < 4; f++) begin
            for (int i = 0; i < 256; i++) begin
                string t;
                case (f)
                    0: t = "R5 R4 R2";
                    1: t = "R6 R4 R2";
                    2: t = "R7 R4 R2";
                    default: t = "R8 R4 R2";
                endcase
                step(1, i, f, 0, 0, '0, t);
            end
        end
        step(0, 0, 0, 0, 0, '0, "");
        // R3: the intensity bit set versus clear gives an identical pixel.
        step(0, 0, 0, 1, 3, 32'hffff_ffff, "");
        step(1, 6, 3, 0, 0, '0, "R3 set");
        step(1, 7, 3, 0, 0, '0, "R3 set");
        step(0, 0, 0, 1, 3, 32'h7fff_7fff, "");
        step(1, 6, 3, 0, 0, '0, "R3 clear");
        step(1, 7, 3, 0, 0, '0, "R3 clear");
        // R10: a write and a lookup to the same entry in one cycle.
        step(1, 20, 3, 1, 10, 32'h1234_4321, "R10 old even");
        step(1, 20, 3, 0, 0, '0, "R10 new even");
        step(1, 21, 1, 1, 10, 32'h0bad_7001, "R10 old odd");
        step(1, 21, 1, 0, 0, '0, "R10 new odd");
        step(1, 20, 0, 0, 0, '0, "R10 new even fmt0");
        step(0, 0, 0, 0, 0, '0, "");
        step(0, 0, 0, 0, 0, '0, "");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule